// File: doc/BRIEF.md
# Multiplexed Bus Cycle Sequencer

This block turns single transfer requests into processor-style bus cycles on a shared address/data bus. Each cycle walks through four phases, T1 to T4, with any number of wait phases (Tw) between T3 and T4. In T1 the address goes out on the shared lines and a latch pulse tells external logic to hold it. From T2 onward the lines either carry write data or are released so that a device can return read data. A separate read strobe or write strobe marks the data phase, and a data-enable strobe frames it. A slow device holds the ready input low to stretch the cycle.

A second bus master can ask for the bus with a hold input. The request is honoured only while no cycle is running. While the grant is held, the sequencer stops driving the bus lines and its control strobes, and it accepts no new transfer. Read data is returned on a register together with a one-clock completion pulse.

Top module: `bus_cycle_seq`

## Requirements
- R1: `ale` is high for exactly one clock, the T1 phase, which is the clock after a request is taken. It is low in every other phase, including the hold grant.
- R2: `bhe_n` is low only during T1, and only when the request had `req_bhe` = 1. It is high at all other times.
- R3: For a read (`req_write` = 0), `rd_n` is low in T2, T3 and every Tw, and high in T1, T4 and idle. A write never drives `rd_n` low.
- R4: For a write (`req_write` = 1), `wr_n` is low in T2, T3 and every Tw, and high otherwise. A read never drives `wr_n` low.
- R5: `ready` is sampled on the edge that ends T3 and on the edge that ends each Tw. A low sample inserts one more Tw. A cycle with N low samples lasts 4+N clocks, counted from T1 through T4.
- R6: `den` is high from T2 through T4 of every cycle, and low in T1, idle and the hold grant.
- R7: In T1, `ad_oe` = 1 and `ad_out` carries the request address. In T2 to T4 of a write, `ad_oe` = 1 and `ad_out[DW-1:0]` carries the write data. In T2 to T4 of a read, `ad_oe` = 0.
- R8: For a read, `rd_data` takes the value of `ad_in[DW-1:0]` on the edge that ends the last T3 or Tw, meaning the edge where `ready` is high. It then holds that value until the next read completes.
- R9: `done` is high for exactly one clock, in T4 of each cycle.
- R10: When `hold` is high while the sequencer is idle, `hlda` rises on the next clock. While `hlda` is high, `ctl_oe` = 0, `ad_oe` = 0 and no request is taken. `hlda` falls on the clock after `hold` falls.
- R11: If `hold` rises during a cycle, the cycle runs to T4 unchanged. `hlda` rises only after T4 has completed.
- R12: During reset, `ale`, `den`, `done`, `hlda` and `ad_oe` are 0, `rd_n`, `wr_n` and `bhe_n` are 1, and `rd_data` is 0.
- R13: `req_accept` is high exactly when the sequencer is idle, `req_valid` is 1 and `hold` is 0. `hold` takes priority over a request that arrives in the same clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A transfer request is present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Transfer address |
| req_bhe | input | 1 | The transfer uses the high byte of the bus |
| req_wdata | input | DW | Write data |
| req_accept | output | 1 | The request is taken on this clock edge |
| ad_out | output | AW | Value driven onto the shared address/data lines |
| ad_oe | output | 1 | Output enable for the shared lines |
| ad_in | input | AW | Value read back from the shared lines |
| ale | output | 1 | Address latch pulse |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| bhe_n | output | 1 | High-byte enable, active low |
| den | output | 1 | Data-enable strobe, active high |
| ctl_oe | output | 1 | Output enable for the control strobes; 0 lets them float |
| ready | input | 1 | The device is ready; low inserts wait states |
| rd_data | output | DW | Data captured by the last read |
| done | output | 1 | Cycle completion pulse |
| hold | input | 1 | Another master requests the bus |
| hlda | output | 1 | The bus is granted to the other master |

## Verification
The hardest cases to reach are the ones where timing decides the result. One is a hold request that arrives in the middle of a stretched cycle. Another is a read whose data appears on the bus only on the clock whose ready sample ends the cycle. The driver raises `hold` during T2 and confirms that the grant stays low through T3, the wait phases and T4, and that it rises only after the idle clock that follows. During wait phases the driver puts the inverse of the expected data on `ad_in`. It puts the true value there only in the phase whose `ready` sample is high, so a capture on the wrong edge returns the wrong word.

// File: rtl/bcs_pkg.sv
package bcs_pkg;

  typedef enum logic [2:0] {
    S_IDLE = 3'd0,
    S_T1   = 3'd1,
    S_T2   = 3'd2,
    S_T3   = 3'd3,
    S_TW   = 3'd4,
    S_T4   = 3'd5,
    S_HELD = 3'd6
  } bstate_t;

  // Phases in which the read or write strobe is active
  function automatic logic strobe_phase(bstate_t s);
    return (s == S_T2) || (s == S_T3) || (s == S_TW);
  endfunction

  // Phases in which the data-enable strobe is active
  function automatic logic data_phase(bstate_t s);
    return strobe_phase(s) || (s == S_T4);
  endfunction

  // Phases ended by an edge that samples ready
  function automatic logic sample_phase(bstate_t s);
    return (s == S_T3) || (s == S_TW);
  endfunction

  // Successor of a sampling phase
  function automatic bstate_t after_sample(logic rdy);
    return rdy ? S_T4 : S_TW;
  endfunction

endpackage

// File: rtl/bcs_fsm.sv
module bcs_fsm
  import bcs_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    req_valid,
  input  logic    hold,
  input  logic    ready,
  output bstate_t state,
  output logic    req_accept,
  output logic    rdy_sample,
  output logic    capture
);

  bstate_t nxt;

  assign req_accept = (state == S_IDLE) && req_valid && !hold;
  assign rdy_sample = sample_phase(state);
  assign capture    = rdy_sample && ready;

  always_comb begin
    nxt = state;
    unique case (state)
      S_IDLE: begin
        if (hold)           nxt = S_HELD;
        else if (req_valid) nxt = S_T1;
      end
      S_T1:   nxt = S_T2;
      S_T2:   nxt = S_T3;
      S_T3:   nxt = after_sample(ready);
      S_TW:   nxt = after_sample(ready);
      S_T4:   nxt = S_IDLE;
      S_HELD: if (!hold) nxt = S_IDLE;
      default: nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= S_IDLE;
    else        state <= nxt;
  end

endmodule

// File: rtl/bcs_strobes.sv
module bcs_strobes
  import bcs_pkg::*;
(
  input  bstate_t state,
  input  logic    cur_write,
  input  logic    cur_bhe,
  output logic    ale,
  output logic    rd_n,
  output logic    wr_n,
  output logic    bhe_n,
  output logic    den,
  output logic    ctl_oe,
  output logic    done,
  output logic    hlda
);

  logic strobe;

  assign strobe = strobe_phase(state);
  assign ale    = (state == S_T1);
  assign rd_n   = !(strobe && !cur_write);
  assign wr_n   = !(strobe && cur_write);
  assign bhe_n  = !((state == S_T1) && cur_bhe);
  assign den    = data_phase(state);
  assign hlda   = (state == S_HELD);
  assign ctl_oe = !hlda;
  assign done   = (state == S_T4);

endmodule

// File: rtl/bcs_datapath.sv
module bcs_datapath
  import bcs_pkg::*;
#(
  parameter int AW = 20,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  bstate_t       state,
  input  logic          req_accept,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic          req_bhe,
  input  logic [DW-1:0] req_wdata,
  input  logic          capture,
  input  logic [AW-1:0] ad_in,
  output logic [AW-1:0] ad_out,
  output logic          ad_oe,
  output logic [DW-1:0] rd_data,
  output logic          cur_write,
  output logic          cur_bhe
);

  localparam int PAD = AW - DW;

  logic [AW-1:0] cur_addr;
  logic [DW-1:0] cur_wdata;
  logic [AW-1:0] wdata_ext;

  generate
    if (PAD > 0) begin : g_pad
      assign wdata_ext = {{PAD{1'b0}}, cur_wdata};
    end else begin : g_nopad
      assign wdata_ext = cur_wdata;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_addr  <= '0;
      cur_wdata <= '0;
      cur_write <= 1'b0;
      cur_bhe   <= 1'b0;
    end else if (req_accept) begin
      cur_addr  <= req_addr;
      cur_wdata <= req_wdata;
      cur_write <= req_write;
      cur_bhe   <= req_bhe;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                      rd_data <= '0;
    else if (capture && !cur_write)  rd_data <= ad_in[DW-1:0];
  end

  assign ad_oe  = (state == S_T1) || (data_phase(state) && cur_write);
  assign ad_out = (state == S_T1) ? cur_addr : wdata_ext;

endmodule

// File: rtl/bus_cycle_seq.sv
module bus_cycle_seq
  import bcs_pkg::*;
#(
  parameter int AW = 20,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic          req_bhe,
  input  logic [DW-1:0] req_wdata,
  output logic          req_accept,
  output logic [AW-1:0] ad_out,
  output logic          ad_oe,
  input  logic [AW-1:0] ad_in,
  output logic          ale,
  output logic          rd_n,
  output logic          wr_n,
  output logic          bhe_n,
  output logic          den,
  output logic          ctl_oe,
  input  logic          ready,
  output logic [DW-1:0] rd_data,
  output logic          done,
  input  logic          hold,
  output logic          hlda
);

  bstate_t state;
  logic    rdy_sample;
  logic    capture;
  logic    cur_write;
  logic    cur_bhe;

  bcs_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .hold       (hold),
    .ready      (ready),
    .state      (state),
    .req_accept (req_accept),
    .rdy_sample (rdy_sample),
    .capture    (capture)
  );

  bcs_datapath #(.AW(AW), .DW(DW)) u_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .state      (state),
    .req_accept (req_accept),
    .req_write  (req_write),
    .req_addr   (req_addr),
    .req_bhe    (req_bhe),
    .req_wdata  (req_wdata),
    .capture    (capture),
    .ad_in      (ad_in),
    .ad_out     (ad_out),
    .ad_oe      (ad_oe),
    .rd_data    (rd_data),
    .cur_write  (cur_write),
    .cur_bhe    (cur_bhe)
  );

  bcs_strobes u_str (
    .state     (state),
    .cur_write (cur_write),
    .cur_bhe   (cur_bhe),
    .ale       (ale),
    .rd_n      (rd_n),
    .wr_n      (wr_n),
    .bhe_n     (bhe_n),
    .den       (den),
    .ctl_oe    (ctl_oe),
    .done      (done),
    .hlda      (hlda)
  );

endmodule

// File: rtl/bcs_checker.sv
module bcs_checker #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_accept,
  input logic          hold,
  input logic          ready,
  input logic          rdy_sample,
  input logic          ale,
  input logic          rd_n,
  input logic          wr_n,
  input logic          bhe_n,
  input logic          den,
  input logic          ctl_oe,
  input logic          ad_oe,
  input logic          done,
  input logic          hlda,
  input logic [DW-1:0] rd_data
);

  assert_ale_after_accept_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_accept |=> ale);

  assert_ale_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ale |=> !ale);

  assert_bhe_in_t1_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !bhe_n |-> ale);

  assert_rd_framed_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n |-> (den && wr_n));

  assert_wr_framed_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_n |-> (den && rd_n));

  assert_wait_holds_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rdy_sample && !ready) |=> ((!rd_n || !wr_n) && !done));

  assert_ready_ends_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rdy_sample && ready) |=> (done && rd_n && wr_n));

  assert_rd_data_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(rdy_sample && ready) |=> $stable(rd_data));

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_grant_floats_R10: assert property (@(posedge clk) disable iff (!rst_n)
    hlda |-> (!ctl_oe && !ad_oe && !ale && !den));

  assert_no_grant_midcycle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (den || ale) |=> !hlda);

  assert_hold_priority_R13: assert property (@(posedge clk) disable iff (!rst_n)
    req_accept |-> !hold);

endmodule

bind bus_cycle_seq bcs_checker #(.DW(DW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_accept (req_accept),
  .hold       (hold),
  .ready      (ready),
  .rdy_sample (rdy_sample),
  .ale        (ale),
  .rd_n       (rd_n),
  .wr_n       (wr_n),
  .bhe_n      (bhe_n),
  .den        (den),
  .ctl_oe     (ctl_oe),
  .ad_oe      (ad_oe),
  .done       (done),
  .hlda       (hlda),
  .rd_data    (rd_data)
);

// File: tb/bus_cycle_seq_test.sv
`timescale 1ns/1ps
module bus_cycle_seq_test;

  localparam int AW = 20;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          req_valid, req_write, req_bhe;
  logic [AW-1:0] req_addr;
  logic [DW-1:0] req_wdata;
  logic          req_accept;
  logic [AW-1:0] ad_out, ad_in;
  logic          ad_oe, ale, rd_n, wr_n, bhe_n, den, ctl_oe;
  logic          ready;
  logic [DW-1:0] rd_data;
  logic          done, hold, hlda;

  always #2.5 clk = ~clk;

  bus_cycle_seq #(.AW(AW), .DW(DW)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_bhe(req_bhe), .req_wdata(req_wdata),
    .req_accept(req_accept), .ad_out(ad_out), .ad_oe(ad_oe), .ad_in(ad_in),
    .ale(ale), .rd_n(rd_n), .wr_n(wr_n), .bhe_n(bhe_n), .den(den),
    .ctl_oe(ctl_oe), .ready(ready), .rd_data(rd_data), .done(done),
    .hold(hold), .hlda(hlda)
  );

  typedef struct {
    logic          wr;
    logic [DW-1:0] rdv;
    int            len;
  } exp_t;

  exp_t sb_q[$];
  int   nchk = 0;
  int   nfail = 0;
  int   cyc = 0;
  int   t1cyc = 0;
  bit   finished = 0;

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Scoreboard monitor: cycle length and read data at each completion
  always @(negedge clk) begin
    if (rst_n) begin
      cyc++;
      if (ale) t1cyc = cyc;
      if (done) begin
        if (sb_q.size() == 0) begin
          check(1'b0, "R9 unexpected done", 32'd1, 32'd0);
        end else begin
          exp_t e;
          e = sb_q.pop_front();
          check((cyc - t1cyc + 1) == e.len, "R5 cycle length",
                cyc - t1cyc + 1, e.len);
          if (!e.wr) check(rd_data == e.rdv, "R8 read data", rd_data, e.rdv);
        end
      end
    end
  end

  task automatic strobe_checks(input logic wr, input string ph);
    check(rd_n == wr, {"R3 rd_n in ", ph}, rd_n, wr);
    check(wr_n == !wr, {"R4 wr_n in ", ph}, wr_n, !wr);
    check(den == 1'b1, {"R6 den in ", ph}, den, 1);
    check(ad_oe == wr, {"R7 ad_oe in ", ph}, ad_oe, wr);
    check(done == 1'b0, {"R9 done in ", ph}, done, 0);
  endtask

  // Driver: called at a negedge with the sequencer idle
  task automatic run_cycle(input logic wr, input logic [AW-1:0] a, input logic bh,
                           input logic [DW-1:0] wd, input int nw,
                           input logic [DW-1:0] rdv, input bit hold_mid);
    exp_t e;
    e.wr = wr; e.rdv = rdv; e.len = 4 + nw;
    sb_q.push_back(e);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_bhe = bh; req_wdata = wd;
    #1;
    check(req_accept == 1'b1, "R13 accept when idle", req_accept, 1);
    @(negedge clk); // T1
    req_valid = 1'b0;
    check(ale == 1'b1, "R1 ale in T1", ale, 1);
    check(bhe_n == !bh, "R2 bhe_n in T1", bhe_n, !bh);
    check(ad_oe == 1'b1 && ad_out == a, "R7 address in T1", ad_out, a);
    check(rd_n && wr_n, "R3 R4 strobes idle in T1", {rd_n, wr_n}, 2'b11);
    check(den == 1'b0, "R6 den low in T1", den, 0);
    @(negedge clk); // T2
    if (hold_mid) hold = 1'b1;
    strobe_checks(wr, "T2");
    check(ale == 1'b0 && bhe_n == 1'b1, "R1 R2 ale/bhe_n off in T2", {ale, bhe_n}, 2'b01);
    if (wr) check(ad_out[DW-1:0] == wd, "R7 write data", ad_out[DW-1:0], wd);
    @(negedge clk); // T3
    strobe_checks(wr, "T3");
    if (hold_mid) check(hlda == 1'b0, "R11 no grant in T3", hlda, 0);
    ready = (nw == 0);
    ad_in = (nw == 0) ? AW'(rdv) : AW'(~rdv);
    for (int k = 1; k <= nw; k++) begin
      @(negedge clk); // Tw
      strobe_checks(wr, "Tw");
      if (hold_mid) check(hlda == 1'b0, "R11 no grant in Tw", hlda, 0);
      ready = (k == nw);
      ad_in = (k == nw) ? AW'(rdv) : AW'(~rdv);
    end
    @(negedge clk); // T4
    ready = 1'b1;
    ad_in = AW'(~rdv);
    check(done == 1'b1, "R9 done in T4", done, 1);
    check(rd_n && wr_n, "R3 R4 strobes off in T4", {rd_n, wr_n}, 2'b11);
    check(den == 1'b1, "R6 den in T4", den, 1);
    if (hold_mid) check(hlda == 1'b0, "R11 no grant in T4", hlda, 0);
    @(negedge clk); // idle
    check(done == 1'b0, "R9 done single clock", done, 0);
    check(den == 1'b0, "R6 den off after T4", den, 0);
    if (!wr) check(rd_data == rdv, "R8 rd_data held", rd_data, rdv);
    if (hold_mid) check(hlda == 1'b0, "R11 grant not before idle", hlda, 0);
  endtask

  initial begin
    #1_000_000;
    if (!finished) begin
      nchk++; nfail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_bhe = 1'b0;
    req_wdata = '0; ad_in = '0; ready = 1'b1; hold = 1'b0;
    repeat (3) @(negedge clk);
    check(!ale && !den && !done && !hlda && !ad_oe, "R12 reset outputs low",
          {ale, den, done, hlda, ad_oe}, 0);
    check(rd_n && wr_n && bhe_n, "R12 reset strobes high", {rd_n, wr_n, bhe_n}, 3'b111);
    check(rd_data == '0, "R12 reset rd_data", rd_data, 0);
    rst_n = 1'b1;
    @(negedge clk);

    run_cycle(1'b0, 20'h12345, 1'b1, 16'h0000, 0, 16'hA5C3, 1'b0);
    run_cycle(1'b1, 20'hF0F0E, 1'b0, 16'h5AA5, 0, 16'h0000, 1'b0);
    run_cycle(1'b0, 20'h00F01, 1'b0, 16'h0000, 3, 16'h1357, 1'b0);
    run_cycle(1'b1, 20'h80001, 1'b1, 16'hBEEF, 2, 16'h0000, 1'b0);

    // Hold raised mid-cycle
    run_cycle(1'b0, 20'h44444, 1'b1, 16'h0000, 2, 16'hC0DE, 1'b1);
    @(negedge clk);
    check(hlda == 1'b1, "R11 grant after cycle", hlda, 1);
    check(!ctl_oe && !ad_oe, "R10 float while granted", {ctl_oe, ad_oe}, 0);
    req_valid = 1'b1; req_write = 1'b0; req_addr = 20'h11111;
    #1;
    check(req_accept == 1'b0, "R10 no accept while granted", req_accept, 0);
    repeat (3) begin
      @(negedge clk);
      check(!ale && hlda, "R10 no cycle while granted", {ale, hlda}, 2'b01);
    end
    req_valid = 1'b0; hold = 1'b0;
    @(negedge clk);
    check(hlda == 1'b0 && ctl_oe == 1'b1, "R10 release", {hlda, ctl_oe}, 2'b01);

    // Hold and request in the same idle clock
    hold = 1'b1; req_valid = 1'b1;
    #1;
    check(req_accept == 1'b0, "R13 hold priority", req_accept, 1'b0);
    @(negedge clk);
    check(hlda == 1'b1 && ale == 1'b0, "R10 grant from idle", {hlda, ale}, 2'b10);
    req_valid = 1'b0; hold = 1'b0;
    @(negedge clk);

    for (int i = 0; i < 6; i++) begin
      run_cycle(i[0], AW'(20'h0ABC0 + i * 20'h111), i[1], DW'(16'h3000 + i),
                i % 4, DW'(16'h9000 + i * 16'h0101), 1'b0);
    end

    repeat (3) @(negedge clk);
    check(sb_q.size() == 0, "R9 all cycles completed", sb_q.size(), 0);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

endmodule